// File: doc/BRIEF.md
# Supervisor and Guest Timer Compare Interrupt Unit

This block raises two level-sensitive timer interrupt-pending bits, one for the supervisor level and one for a virtualised (guest) supervisor level. Both watch one shared 64-bit free-running time count that arrives from outside together with a tick strobe. The supervisor path compares the time count directly against its own compare register. The guest path first adds a 64-bit guest time offset, modulo 2^64, and then compares that sum against a second compare register.

Software writes the two compare registers and the offset through write ports that have one enable per 32-bit half. A 32-bit processor can therefore update a register in two accesses. Each pending bit is gated by layered enables. The supervisor path needs the machine-level timer enable. The guest path also needs a hypervisor-level timer enable and a strap that says the hypervisor exists. Both compare registers can be read back. The pending bits are registered, and they reflect the new value of a written compare register on the same clock edge that stores it.

Top module: `sup_timer_irq`

## Requirements
- R1: While reset is high, and on the first edge after it, both compare read-backs, the held time value, the guest offset and both pending outputs are 0.
- R2: `s_pend_o` is 1 exactly when the machine enable is set and the held time, read as an unsigned number, is greater than or equal to the supervisor compare register.
- R3: `vs_pend_o` uses the same greater-or-equal rule, but compares (held time + guest offset) mod 2^64 against the guest compare register. There is no carry-out and no saturation.
- R4: When `m_tmr_en_i` is 0, `s_pend_o` is 0 on the next edge, whatever the compare outcome.
- R5: `vs_pend_o` can be 1 only when `hyp_present_i`, `m_tmr_en_i` and `h_tmr_en_i` are all 1. With any of them at 0, it is 0 on the next edge.
- R6: A compare write is evaluated on the edge that stores it. Writing a value above the held time clears the pending bit on that same edge.
- R7: Each write port has a 2-bit enable. Bit 0 writes data bits 31:0 and bit 1 writes bits 63:32. A half whose enable is 0 keeps its old value, and the read-back shows the merged result.
- R8: With a compare value of all-ones, pending is 1 while the compared time is all-ones. It drops on the next tick, when that time wraps to 0.
- R9: When an enable goes from 0 to 1, the comparison resumes against the stored compare value on the next edge, and no rewrite is needed.
- R10: `time_i` is captured only on an edge where `tick_i` is 1. Between ticks, both paths keep comparing against the last captured value. Pending follows a tick one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Capture strobe for `time_i` |
| time_i | input | 64 | Free-running time count |
| m_tmr_en_i | input | 1 | Machine-level timer enable |
| h_tmr_en_i | input | 1 | Hypervisor-level timer enable |
| hyp_present_i | input | 1 | Strap: hypervisor implemented |
| s_cmp_we_i | input | 2 | Half write enables, supervisor compare |
| s_cmp_wdata_i | input | 64 | Write data, supervisor compare |
| vs_cmp_we_i | input | 2 | Half write enables, guest compare |
| vs_cmp_wdata_i | input | 64 | Write data, guest compare |
| gofs_we_i | input | 2 | Half write enables, guest offset |
| gofs_wdata_i | input | 64 | Write data, guest offset |
| s_cmp_o | output | 64 | Supervisor compare read-back |
| vs_cmp_o | output | 64 | Guest compare read-back |
| s_pend_o | output | 1 | Supervisor timer pending |
| vs_pend_o | output | 1 | Guest timer pending |

## Verification
The bench sweeps time across each compare value. A design that used strict greater-than would miss the equality cycle, and one that compared signed values would fail near the top bit. It places the compare value at all-ones and ticks time through the wrap to 0. A design that latched pending, or that skipped re-evaluation at the all-ones point, would then keep the bit set. It uses a guest offset that makes the sum overflow, which exposes saturating or carry-extended addition. It also walks all eight combinations of the enable bits and the hypervisor strap, writes single halves, and raises an enable again without rewriting the compare value. A design with broken lane merging, a missing gate, or pending logic that re-arms only on a write would fail these checks.

// File: rtl/stimer_pkg.sv
package stimer_pkg;

    localparam int unsigned TIME_W_DEF = 64;
    localparam int unsigned LANE_W_DEF = 32;

    typedef struct packed {
        logic hyp;
        logic m_en;
        logic h_en;
    } tmr_gate_t;

    function automatic logic s_gate_open(input tmr_gate_t g);
        return g.m_en;
    endfunction

    function automatic logic vs_gate_open(input tmr_gate_t g);
        return g.hyp & g.m_en & g.h_en;
    endfunction

endpackage

// File: rtl/stimer_wreg.sv
module stimer_wreg #(
    parameter int unsigned W      = 64,
    parameter int unsigned LANE_W = 32,
    localparam int unsigned NL    = W / LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q,
    output logic [W-1:0]  nxt
);

    // per-lane merge of new data into the held value
    for (genvar l = 0; l < NL; l++) begin : g_lane
        assign nxt[l*LANE_W +: LANE_W] = we[l] ? wdata[l*LANE_W +: LANE_W]
                                               : q[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/stimer_cmp_path.sv
module stimer_cmp_path #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] time_nx,
    input  logic [W-1:0] ofs_nx,
    input  logic [W-1:0] cmp_nx,
    input  logic         gate,
    output logic         pend_q
);

    logic [W-1:0] eff_time;
    logic         hit;

    // sum wraps modulo 2^W; carry discarded by width
    assign eff_time = time_nx + ofs_nx;
    assign hit      = gate & (eff_time >= cmp_nx);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= hit;
    end

endmodule

// File: rtl/sup_timer_irq.sv
module sup_timer_irq
    import stimer_pkg::*;
#(
    parameter int unsigned TW     = TIME_W_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF,
    localparam int unsigned NL    = TW / LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [TW-1:0] time_i,
    input  logic          m_tmr_en_i,
    input  logic          h_tmr_en_i,
    input  logic          hyp_present_i,
    input  logic [NL-1:0] s_cmp_we_i,
    input  logic [TW-1:0] s_cmp_wdata_i,
    input  logic [NL-1:0] vs_cmp_we_i,
    input  logic [TW-1:0] vs_cmp_wdata_i,
    input  logic [NL-1:0] gofs_we_i,
    input  logic [TW-1:0] gofs_wdata_i,
    output logic [TW-1:0] s_cmp_o,
    output logic [TW-1:0] vs_cmp_o,
    output logic          s_pend_o,
    output logic          vs_pend_o
);

    tmr_gate_t     gate;
    logic [TW-1:0] time_q, time_nx;
    logic [TW-1:0] s_cmp_nx, vs_cmp_nx, gofs_q, gofs_nx;

    assign gate = '{hyp: hyp_present_i, m_en: m_tmr_en_i, h_en: h_tmr_en_i};

    // held copy of the time count, refreshed on tick
    assign time_nx = tick_i ? time_i : time_q;

    always_ff @(posedge clk) begin
        if (rst) time_q <= '0;
        else     time_q <= time_nx;
    end

    stimer_wreg #(.W(TW), .LANE_W(LANE_W)) u_s_cmp (
        .clk(clk), .rst(rst), .we(s_cmp_we_i), .wdata(s_cmp_wdata_i),
        .q(s_cmp_o), .nxt(s_cmp_nx)
    );

    stimer_wreg #(.W(TW), .LANE_W(LANE_W)) u_vs_cmp (
        .clk(clk), .rst(rst), .we(vs_cmp_we_i), .wdata(vs_cmp_wdata_i),
        .q(vs_cmp_o), .nxt(vs_cmp_nx)
    );

    stimer_wreg #(.W(TW), .LANE_W(LANE_W)) u_gofs (
        .clk(clk), .rst(rst), .we(gofs_we_i), .wdata(gofs_wdata_i),
        .q(gofs_q), .nxt(gofs_nx)
    );

    stimer_cmp_path #(.W(TW)) u_s_path (
        .clk(clk), .rst(rst), .time_nx(time_nx), .ofs_nx('0),
        .cmp_nx(s_cmp_nx), .gate(s_gate_open(gate)), .pend_q(s_pend_o)
    );

    stimer_cmp_path #(.W(TW)) u_vs_path (
        .clk(clk), .rst(rst), .time_nx(time_nx), .ofs_nx(gofs_nx),
        .cmp_nx(vs_cmp_nx), .gate(vs_gate_open(gate)), .pend_q(vs_pend_o)
    );

    logic unused_ok;
    assign unused_ok = ^gofs_q;

endmodule

// File: rtl/sup_timer_irq_chk.sv
module sup_timer_irq_chk #(
    parameter int unsigned TW = 64,
    parameter int unsigned NL = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_i,
    input logic [TW-1:0] time_i,
    input logic          m_tmr_en_i,
    input logic          h_tmr_en_i,
    input logic          hyp_present_i,
    input logic [NL-1:0] s_cmp_we_i,
    input logic [TW-1:0] s_cmp_o,
    input logic [TW-1:0] vs_cmp_o,
    input logic          s_pend_o,
    input logic          vs_pend_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (s_cmp_o == '0 && vs_cmp_o == '0 && !s_pend_o && !vs_pend_o));

    // R4
    s_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !m_tmr_en_i |=> !s_pend_o);

    // R5
    vs_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!hyp_present_i || !m_tmr_en_i || !h_tmr_en_i) |=> !vs_pend_o);

    // R2
    s_ge_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tmr_en_i && tick_i && s_cmp_we_i == '0 && time_i >= s_cmp_o) |=> s_pend_o);

    // R8
    s_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (s_cmp_o == '1 && tick_i && time_i == '0 && s_cmp_we_i == '0) |=> !s_pend_o);

endmodule

bind sup_timer_irq sup_timer_irq_chk #(.TW(TW), .NL(NL)) u_chk (
    .clk(clk), .rst(rst), .tick_i(tick_i), .time_i(time_i),
    .m_tmr_en_i(m_tmr_en_i), .h_tmr_en_i(h_tmr_en_i),
    .hyp_present_i(hyp_present_i), .s_cmp_we_i(s_cmp_we_i),
    .s_cmp_o(s_cmp_o), .vs_cmp_o(vs_cmp_o),
    .s_pend_o(s_pend_o), .vs_pend_o(vs_pend_o)
);

// File: tb/sup_timer_irq_tb.sv
module sup_timer_irq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [63:0] tin = '0;
    logic        men = 1'b0, hen = 1'b0, hyp = 1'b0;
    logic [1:0]  swe = '0, vwe = '0, owe = '0;
    logic [63:0] swd = '0, vwd = '0, owd = '0;
    logic [63:0] s_rd, vs_rd;
    logic        s_pend, vs_pend;

    int n_chk = 0, n_fail = 0;
    logic [63:0] mt = '0, ms = '0, mv = '0, mo = '0;

    always #4 clk = ~clk;

    sup_timer_irq u_dut (
        .clk(clk), .rst(rst), .tick_i(tick), .time_i(tin),
        .m_tmr_en_i(men), .h_tmr_en_i(hen), .hyp_present_i(hyp),
        .s_cmp_we_i(swe), .s_cmp_wdata_i(swd),
        .vs_cmp_we_i(vwe), .vs_cmp_wdata_i(vwd),
        .gofs_we_i(owe), .gofs_wdata_i(owd),
        .s_cmp_o(s_rd), .vs_cmp_o(vs_rd),
        .s_pend_o(s_pend), .vs_pend_o(vs_pend)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] merge(input logic [63:0] old,
                                          input logic [63:0] d, input logic [1:0] we);
        logic [63:0] r = old;
        if (we[0]) r[31:0]  = d[31:0];
        if (we[1]) r[63:32] = d[63:32];
        return r;
    endfunction

    // one clock; model advances with the same inputs, then all outputs compared
    task automatic cyc(input string tag);
        logic es, ev;
        logic [63:0] sum;
        if (tick) mt = tin;
        ms = merge(ms, swd, swe);
        mv = merge(mv, vwd, vwe);
        mo = merge(mo, owd, owe);
        sum = mt + mo;
        es = men && (mt >= ms);
        ev = hyp && men && hen && (sum >= mv);
        @(posedge clk); #2;
        swe = '0; vwe = '0; owe = '0; tick = 1'b0;
        chk(tag, "s_pend",  {63'd0, s_pend},  {63'd0, es});
        chk(tag, "vs_pend", {63'd0, vs_pend}, {63'd0, ev});
        chk(tag, "s_cmp",   s_rd,  ms);
        chk(tag, "vs_cmp",  vs_rd, mv);
    endtask

    task automatic set_time(input logic [63:0] t);
        tick = 1'b1; tin = t;
    endtask

    initial begin : watchdog
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1", "s_pend", {63'd0, s_pend}, 64'd0);
        chk("R1", "vs_pend", {63'd0, vs_pend}, 64'd0);
        chk("R1", "s_cmp", s_rd, 64'd0);
        chk("R1", "vs_cmp", vs_rd, 64'd0);
        rst = 1'b0;
        men = 1'b1; hen = 1'b1; hyp = 1'b1;
        cyc("R1");   // time 0 >= cmp 0 -> pending

        // R2: sweep around a compare value
        swd = 64'd100; swe = 2'b11; set_time(64'd50); cyc("R6");
        for (int t = 95; t <= 105; t++) begin
            set_time(64'(t)); cyc("R2");
        end
        swd = 64'h8000_0000_0000_0000; swe = 2'b11; cyc("R2");
        for (int t = -2; t <= 2; t++) begin
            set_time(64'h8000_0000_0000_0000 + 64'(t)); cyc("R2");
        end

        // R7: half writes
        swd = 64'hDEAD_BEEF_0000_0010; swe = 2'b01; cyc("R7");
        swd = 64'h0000_0001_FFFF_FFFF; swe = 2'b10; cyc("R7");
        vwd = 64'h1234_5678_9ABC_DEF0; vwe = 2'b10; cyc("R7");
        vwd = 64'h0; vwe = 2'b01; cyc("R7");

        // R6: write above held time drops pending on the same edge
        swd = 64'd10; swe = 2'b11; set_time(64'd1000); cyc("R6");
        swd = 64'd5000; swe = 2'b11; cyc("R6");
        swd = 64'd1000; swe = 2'b11; cyc("R6");

        // R3: offset sum wraps modulo 2^64
        owd = 64'hFFFF_FFFF_FFFF_FFFB; owe = 2'b11;
        vwd = 64'd5; vwe = 2'b11; cyc("R3");
        for (int t = 8; t <= 12; t++) begin
            set_time(64'(t)); cyc("R3");
        end
        owd = 64'd1 << 40; owe = 2'b11; cyc("R3");
        vwd = (64'd1 << 40) + 64'd20; vwe = 2'b11; cyc("R3");
        set_time(64'd21); cyc("R3");

        // R4 / R5: all enable combinations with both compares satisfied
        swd = 64'd0; swe = 2'b11; vwd = 64'd0; vwe = 2'b11; cyc("R4");
        for (int c = 0; c < 8; c++) begin
            hyp = c[0]; men = c[1]; hen = c[2];
            cyc("R5");
            cyc("R4");
        end

        // R9: resume without rewrite
        hyp = 1'b1; hen = 1'b1; men = 1'b0; cyc("R9");
        men = 1'b1; cyc("R9");
        hen = 1'b0; cyc("R9");
        hen = 1'b1; cyc("R9");

        // R8: all-ones compare across the wrap
        owd = 64'd0; owe = 2'b11;
        swd = '1; swe = 2'b11; vwd = '1; vwe = 2'b11; cyc("R8");
        for (int k = 3; k >= 0; k--) begin
            set_time(~64'(k)); cyc("R8");
        end
        set_time(64'd0); cyc("R8");
        set_time(64'd1); cyc("R8");

        // R10: time_i ignored without tick
        swd = 64'd100; swe = 2'b11; set_time(64'd50); cyc("R10");
        tin = 64'd500; cyc("R10");
        tin = 64'd900; cyc("R10");
        tick = 1'b1; cyc("R10");
        tin = 64'd3; cyc("R10");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule